// File: doc/BRIEF.md
# Power-Mode-Aware Frame Sequencer for a Serial ADC

This block is the host side of a four-wire serial link to a 12-bit sampling converter. It runs the link continuously from reset: it opens a frame by pulling chip select low, clocks exactly sixteen serial clock periods, shifts a control word out on the data-in line and collects the converter's reply on the data-out line. Conversion results reach the rest of the chip through a single valid/ready output. No other buffering is provided, so a result that has not been taken holds off the next frame.

The converter has three power modes, and the sequencer knows the timing each one needs. In normal mode every frame writes the control register and every result is good. In auto-shutdown mode the converter sleeps after each conversion, so the sequencer puts a wake-up frame with its write bit cleared before each real frame and discards that frame's reply, which halves the result rate. In full shutdown the sequencer stops framing entirely. When it wakes the converter it discards the wake frame's reply and keeps chip select high for a longer power-up interval. Between any two frames chip select stays high for at least a quiet interval. Mode requests are stored when they arrive and take effect from the next frame that starts.

Top module: `adc_seq_host`

## Requirements
- R1: A frame holds `cs_n` low for exactly 16 `sclk` periods, and `sclk` idles high whenever `cs_n` is high. `din` carries the frame MSB first: the first bit appears when `cs_n` falls, each later bit appears when `sclk` rises, and `din` never changes while `sclk` is low. `dout` is sampled at each `sclk` falling transition.
- R2: Frame bits are numbered 15 (first) down to 0. Bit 15 is the write flag, bits 14:13 are the power-mode code (11 normal, 10 full shutdown, 01 auto-shutdown), bits 12:4 copy `cfg` as it was when the frame started, and bits 3:0 are zero.
- R3: While the converter is in normal mode and normal is the requested mode, every frame has the write flag set and power code 11.
- R4: While the converter is in auto-shutdown, each frame with the write flag set comes right after exactly one wake frame that has the write flag cleared. The wake frame's reply is never delivered.
- R5: The result is the last 12 bits sampled in a delivered frame. It is presented on `out_data` with `out_valid` high and stays stable until `out_ready` is seen high. No frame starts while a result is waiting.
- R6: Between two frames, `cs_n` stays high for at least QUIET_CYC system clocks.
- R7: The frame that writes power code 10 delivers its result. After it, no frame starts and `cs_n` stays high until a different mode is requested.
- R8: Leaving full shutdown takes one write frame that carries the new code. Its reply is discarded, and `cs_n` then stays high for at least PWRUP_CYC system clocks before the next frame.
- R9: A request on `mode_req`/`mode_req_valid` is stored and is used by the next frame to start, not by a frame already in progress. Code 00 is ignored.
- R10: During reset `cs_n`, `sclk` are high, `din` is low and `out_valid` is low. After reset the converter is taken to be in normal mode, and normal is the requested mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 2 | Requested power-mode code |
| mode_req_valid | input | 1 | Strobe that stores `mode_req` |
| cfg | input | 9 | Settings field copied into write frames |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 12 | Conversion result |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| din | output | 1 | Serial data to converter |
| dout | input | 1 | Serial data from converter |

## Verification
The bench acts as the converter. It serves a distinct 12-bit value with a nonzero upper nibble in every frame, decodes each frame it receives and predicts from its own power-state model which replies must appear. A design that delivered wake-frame replies, left out the wake frame, or kept the upper nibble would leave the scoreboard out of step. The bench measures chip-select high time before every frame against the quiet and power-up limits, so a design that reused the quiet count after a full-shutdown wake would fail. It also holds `out_ready` low across a frame boundary, watches for frames during full shutdown, and sends code 00 to show that an illegal request does not change the power code in later frames.

// File: rtl/adc_seq_pkg.sv
// Shared types for the serial ADC frame sequencer.
// Assumes a 16-bit frame: 12-bit control word followed by 4 zero bits.
package adc_seq_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CTRL_BITS  = 12;
    localparam int RES_BITS   = 12;
    localparam int CFG_BITS   = CTRL_BITS - 3;
    localparam int PAD_BITS   = FRAME_BITS - CTRL_BITS;

    typedef enum logic [1:0] {
        PM_AUTO   = 2'b01,
        PM_FULL   = 2'b10,
        PM_NORMAL = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        FK_NONE,
        FK_DUMMY,
        FK_WAKE,
        FK_REAL
    } fkind_e;
endpackage

// File: rtl/adc_seq_shifter.sv
// Frame engine: on start, drops cs_n and runs FRAME_BITS serial clock
// periods. DIN changes when sclk rises, and DOUT is sampled when sclk falls.
// Assumes CLK_DIV >= 1 system clocks per sclk half period.
module adc_seq_shifter
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  busy,
    output logic                  done,
    output logic [RES_BITS-1:0]   rx_word,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  din,
    input  logic                  dout
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

    logic                  active;
    logic                  sclk_r;
    logic [DW-1:0]         div_cnt;
    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [RES_BITS-1:0]   rx_sh;
    logic                  phase_end;

    assign phase_end = active && (div_cnt == DIV_LAST);
    assign done      = phase_end && !sclk_r && (bit_cnt == BIT_LAST);
    assign busy      = active;
    assign cs_n      = !active;
    assign sclk      = sclk_r;
    assign din       = active && tx_sh[FRAME_BITS-1];
    assign rx_word   = rx_sh;

    // Sequences half periods, shifts DIN out and collects DOUT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk_r  <= 1'b1;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (!active) begin
            if (start) begin
                active  <= 1'b1;
                tx_sh   <= tx_word;
                bit_cnt <= '0;
                div_cnt <= '0;
                sclk_r  <= 1'b1;
            end
        end else if (phase_end) begin
            div_cnt <= '0;
            if (sclk_r) begin
                sclk_r <= 1'b0;
                rx_sh  <= {rx_sh[RES_BITS-2:0], dout};
            end else if (bit_cnt == BIT_LAST) begin
                active <= 1'b0;
                sclk_r <= 1'b1;
            end else begin
                sclk_r  <= 1'b1;
                bit_cnt <= bit_cnt + 1'b1;
                tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R1: the serial clock only falls inside a frame
    assert_sclk_fall_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);
    // R1: DIN is held while the serial clock is low
    assert_din_hold_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk) && !cs_n && $past(!cs_n)) |-> $stable(din));
    // R1: a frame closes only after the last bit period
    assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(bit_cnt) == BIT_LAST);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Frame policy: chooses the kind of the next frame from the tracked
// converter mode and the requested mode, builds the frame word, enforces
// the quiet and power-up gaps and holds the result for the consumer.
// Assumes the shifter raises done combinationally in its last cycle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int QUIET_CYC = 8,
    parameter int PWRUP_CYC = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_req,
    input  logic                  mode_req_valid,
    input  logic [CFG_BITS-1:0]   cfg,
    input  logic                  busy,
    input  logic                  done,
    input  logic [RES_BITS-1:0]   rx_word,
    output logic                  start,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [RES_BITS-1:0]   out_data
);
    localparam int GAP_MAX = (PWRUP_CYC > QUIET_CYC) ? PWRUP_CYC : QUIET_CYC;
    localparam int GW      = $clog2(GAP_MAX + 1);

    pmode_e              tgt;
    pmode_e              dev;
    pmode_e              pm_sent;
    fkind_e              kind_r;
    fkind_e              next_kind;
    logic                woke;
    logic [GW-1:0]       gap_cnt;
    logic                valid_r;
    logic [RES_BITS-1:0] data_r;

    // Picks the kind of frame to run next.
    always_comb begin
        if (dev == PM_FULL)
            next_kind = (tgt == PM_FULL) ? FK_NONE : FK_WAKE;
        else if (dev == PM_AUTO && !woke)
            next_kind = FK_DUMMY;
        else
            next_kind = FK_REAL;
    end

    assign start     = !busy && (gap_cnt == '0) && !valid_r && (next_kind != FK_NONE);
    assign tx_word   = {next_kind != FK_DUMMY, tgt, cfg, {PAD_BITS{1'b0}}};
    assign out_valid = valid_r;
    assign out_data  = data_r;

    // Stores legal mode requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt <= PM_NORMAL;
        else if (mode_req_valid && mode_req != 2'b00)
            tgt <= pmode_e'(mode_req);
    end

    // Tracks the frame in flight and the converter's power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev     <= PM_NORMAL;
            pm_sent <= PM_NORMAL;
            kind_r  <= FK_NONE;
            woke    <= 1'b0;
        end else if (start) begin
            kind_r  <= next_kind;
            pm_sent <= tgt;
        end else if (done) begin
            if (kind_r == FK_DUMMY) begin
                woke <= 1'b1;
            end else begin
                dev  <= pm_sent;
                woke <= 1'b0;
            end
        end
    end

    // Counts the chip-select high gap after each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (done)
            gap_cnt <= (kind_r == FK_WAKE) ? GW'(PWRUP_CYC) : GW'(QUIET_CYC);
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
    end

    // Holds a delivered result until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= 1'b0;
            data_r  <= '0;
        end else if (done && kind_r == FK_REAL) begin
            valid_r <= 1'b1;
            data_r  <= rx_word;
        end else if (out_ready) begin
            valid_r <= 1'b0;
        end
    end

    // R5: a waiting result is held stable
    assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R5: a frame never starts over a waiting result
    assert_no_start_waiting_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !out_valid && !busy);
    // R4: an asleep auto-shutdown converter gets a non-writing frame
    assert_auto_wake_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dev == PM_AUTO && !woke) |-> !tx_word[FRAME_BITS-1]);
    // R7: no framing while full shutdown is both current and requested
    assert_full_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev == PM_FULL && tgt == PM_FULL) |-> !start);
endmodule

// File: rtl/adc_seq_host.sv
// Top of the serial ADC sequencer: joins the frame policy to the frame
// engine. Assumes a converter that samples DIN on sclk falls and holds
// DOUT valid at those falls.
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int QUIET_CYC = 8,
    parameter int PWRUP_CYC = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_req,
    input  logic                mode_req_valid,
    input  logic [CFG_BITS-1:0] cfg,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [RES_BITS-1:0] out_data,
    output logic                cs_n,
    output logic                sclk,
    output logic                din,
    input  logic                dout
);
    localparam int HW = $clog2(QUIET_CYC + 1);

    logic                  start;
    logic                  busy;
    logic                  done;
    logic [FRAME_BITS-1:0] tx_word;
    logic [RES_BITS-1:0]   rx_word;

    adc_seq_ctrl #(
        .QUIET_CYC(QUIET_CYC),
        .PWRUP_CYC(PWRUP_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_req(mode_req), .mode_req_valid(mode_req_valid), .cfg(cfg),
        .busy(busy), .done(done), .rx_word(rx_word),
        .start(start), .tx_word(tx_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    adc_seq_shifter #(
        .CLK_DIV(CLK_DIV)
    ) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start), .tx_word(tx_word),
        .busy(busy), .done(done), .rx_word(rx_word),
        .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout)
    );

    // Checker state: saturating count of chip-select high cycles.
    logic [HW-1:0] hi_cnt;
    logic          seen_frame;

    // Measures the gap between frames for the quiet-time check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (start) seen_frame <= 1'b1;
            if (!cs_n) hi_cnt <= '0;
            else if (hi_cnt != HW'(QUIET_CYC)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R6: quiet gap honoured before every frame after the first
    assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seen_frame) |-> hi_cnt == HW'(QUIET_CYC));
endmodule

// File: tb/adc_seq_host_tb.sv
module adc_seq_host_tb;
    localparam int CLK_DIV = 2;
    localparam int QUIET   = 6;
    localparam int PWRUP   = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_req;
    logic       mode_req_valid;
    logic [8:0] cfg;
    logic       out_valid;
    logic       out_ready;
    logic [11:0] out_data;
    logic       cs_n, sclk, din;
    logic       dout;

    always #4 clk = ~clk;

    adc_seq_host #(.CLK_DIV(CLK_DIV), .QUIET_CYC(QUIET), .PWRUP_CYC(PWRUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_req_valid(mode_req_valid),
        .cfg(cfg), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model state
    logic [1:0]  bmode = 2'b11;
    logic [1:0]  tb_tgt = 2'b11;
    logic [1:0]  tgt_at_start;
    logic [8:0]  cfg_at_start;
    bit          prev_dummy = 0;
    bit          last_wake = 0;
    bit          seen = 0;
    bit          in_frame = 0;
    int          starts = 0;
    int          frames_done = 0;
    int          nfall = 0;
    int          hi_len = 0;
    logic [15:0] dword = '0;
    logic [15:0] rxd = '0;
    logic [11:0] val = 12'h123;

    always_comb dout = (nfall < 16) ? dword[15 - nfall] : 1'b0;

    always @(posedge clk) hi_len <= cs_n ? hi_len + 1 : 0;

    // Frame opens: serve a fresh value and check the gap (R6, R8)
    always @(negedge cs_n) begin
        if (rst_n) begin
            if (seen)
                chk(hi_len >= (last_wake ? PWRUP : QUIET), last_wake ? "R8" : "R6",
                    hi_len, last_wake ? PWRUP : QUIET);
            seen = 1;
            in_frame = 1;
            starts++;
            val = val + 12'h1d3;
            dword = {4'hA, val};
            nfall = 0;
            tgt_at_start = tb_tgt;
            cfg_at_start = cfg;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            rxd = {rxd[14:0], din};
            nfall++;
        end
    end

    // Frame closes: decode and predict delivery
    always @(posedge cs_n) begin
        if (in_frame && rst_n) begin
            bit wr;
            logic [1:0] pm;
            bit vld;
            in_frame = 0;
            wr = rxd[15];
            pm = rxd[14:13];
            chk(nfall == 16, "R1", nfall, 16);
            chk(rxd[3:0] == 4'h0, "R2", int'(rxd[3:0]), 0);
            if (wr) begin
                chk(rxd[12:4] == cfg_at_start, "R2", int'(rxd[12:4]), int'(cfg_at_start));
                chk(pm == tgt_at_start, "R9", int'(pm), int'(tgt_at_start));
                if (bmode == 2'b11 && tgt_at_start == 2'b11)
                    chk(pm == 2'b11, "R3", int'(pm), 3);
                if (bmode == 2'b01)
                    chk(prev_dummy, "R4", int'(prev_dummy), 1);
            end else begin
                chk(bmode == 2'b01 && !prev_dummy, "R4", int'(bmode), 1);
            end
            vld = wr && bmode != 2'b10 && (bmode != 2'b01 || prev_dummy);
            if (vld) q.push_back(int'(dword[11:0]));
            last_wake = wr && bmode == 2'b10;
            if (wr) bmode = pm;
            prev_dummy = !wr;
            frames_done++;
        end
    end

    // Scoreboard monitor (R5)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid && out_ready) begin
            if (q.size() == 0)
                chk(0, "R5", int'(out_data), -1);
            else begin
                int e;
                e = q.pop_front();
                chk(out_data == 12'(e), "R5", int'(out_data), e);
            end
        end
    end

    task automatic wait_frames(input int n);
        int t;
        t = frames_done + n;
        wait (frames_done >= t);
    endtask

    task automatic request(input logic [1:0] m, input bit legal);
        @(negedge clk);
        mode_req = m;
        mode_req_valid = 1'b1;
        if (legal) tb_tgt = m;
        @(negedge clk);
        mode_req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        mode_req = 2'b00;
        mode_req_valid = 1'b0;
        cfg = 9'h15A;
        out_ready = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(cs_n == 1'b1, "R10", int'(cs_n), 1);
        chk(sclk == 1'b1, "R10", int'(sclk), 1);
        chk(din == 1'b0, "R10", int'(din), 0);
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
        rst_n = 1'b1;

        // Normal mode (R3), cfg change between frames (R2)
        wait_frames(3);
        @(posedge cs_n);
        @(negedge clk);
        cfg = 9'h0A5;
        wait_frames(2);

        // Auto-shutdown (R4)
        @(posedge cs_n);
        request(2'b01, 1);
        wait_frames(7);

        // Full shutdown (R7)
        @(posedge cs_n);
        request(2'b10, 1);
        wait (bmode == 2'b10);
        begin
            int s;
            s = starts;
            repeat (1000) @(negedge clk);
            chk(starts == s, "R7", starts - s, 0);
            chk(cs_n == 1'b1, "R7", int'(cs_n), 1);
        end

        // Leave full shutdown (R8)
        request(2'b11, 1);
        wait_frames(4);

        // Back-pressure (R5)
        @(negedge cs_n);
        @(negedge clk);
        out_ready = 1'b0;
        @(posedge cs_n);
        @(negedge clk);
        begin
            int s;
            logic [11:0] held;
            s = starts;
            held = out_data;
            chk(out_valid == 1'b1, "R5", int'(out_valid), 1);
            repeat (300) @(negedge clk);
            chk(out_valid == 1'b1, "R5", int'(out_valid), 1);
            chk(out_data == held, "R5", int'(out_data), int'(held));
            chk(starts == s, "R5", starts - s, 0);
        end
        out_ready = 1'b1;

        // Illegal code ignored (R9)
        wait_frames(1);
        @(posedge cs_n);
        request(2'b00, 0);
        wait_frames(3);

        repeat (200) @(negedge clk);
        chk(q.size() == 0, "R5", q.size(), 0);
        finish_run();
    end
endmodule